// File: doc/BRIEF.md
# SDRAM Refresh Command Scheduler

This block sits on the controller side of a two-bank SDRAM and keeps the memory refreshed. A free-running down-counter marks each refresh interval. When an interval expires, the block raises a request to the access arbiter. The arbiter closes both banks and answers with a grant. The block then drives one AutoRefresh command on the command pins and holds NOPs for the recovery window. It ends the sequence with a one-cycle done pulse, and the arbiter resumes normal traffic after that pulse.

A low-power control input asks for self-refresh. On that request the block wins the bus through the same request and grant handshake. It then issues a parameterised burst of back-to-back refreshes and the self-refresh entry command, which is the refresh encoding with clock-enable driven low. While the input stays high, clock-enable stays low and Deselect is driven. When the input falls, the block raises clock-enable together with a NOP. It then enforces the row-cycle wait, sends a second burst of refreshes, and finishes with the done pulse.

The sequencing is a Moore state machine with these states:
- IDLE: drives Deselect. It goes to REQ when a self-refresh request or a pending periodic refresh is present, and self-refresh has priority.
- REQ: holds ref_req high until ref_gnt. It then goes to REF_CMD, or straight to SR_ENTER when no pre-entry burst is left.
- REF_CMD: drives one AutoRefresh and goes to WAIT.
- WAIT: drives NOPs for the recovery window. At its end it goes to REF_CMD while burst refreshes remain, to SR_ENTER after the pre-entry burst, and otherwise to DONE.
- SR_ENTER: drives the entry command and goes to SR_HOLD.
- SR_HOLD: holds clock-enable low until sr_req falls, then goes to SR_EXIT.
- SR_EXIT: drives a NOP with clock-enable high and goes to SR_WAIT.
- SR_WAIT: waits the row-cycle time. It then goes to REF_CMD for the post-exit burst, or to DONE when that burst is empty.
- DONE: pulses ref_done and returns to IDLE.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and right after reset the block drives Deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1) with cke=1, and ref_req=0, ref_done=0, sr_active=0.
- R2: A periodic refresh becomes pending on clock edge number k·REF_INTERVAL after reset, for every k≥1. When the block is in IDLE, ref_req rises in the cycle after that edge.
- R3: Once raised, ref_req stays high until ref_gnt is seen. No command is issued before the grant. Exactly one AutoRefresh follows each periodic grant, and intervals that expire while a refresh is pending are merged into it. An expiry on the same edge as the refresh that clears the pending flag keeps the flag set.
- R4: AutoRefresh is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=1. It is issued only while ref_req is high after a grant, and only when cke was high in the previous cycle.
- R5: Every AutoRefresh is followed by exactly T_WAIT = max(T_RC, T_RP) cycles of NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, cke=1).
- R6: ref_done is high for exactly one cycle, in the cycle right after the final wait of a sequence, and ref_req is low in that cycle.
- R7: A self-refresh request seen in IDLE has priority over a pending periodic refresh. After the grant, BURST_LEN AutoRefresh commands are issued T_WAIT+1 cycles apart. The entry command (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=0) follows T_WAIT+1 cycles after the last of them.
- R8: After entry, and for as long as sr_req stays high, cke stays 0, Deselect is driven and sr_active is 1.
- R9: If sr_req is first seen low in cycle c of self-refresh (c at or after the entry cycle), cke returns to 1 in cycle max(c, entry+1)+1. That cycle carries a NOP or Deselect and is followed by T_RC NOP cycles.
- R10: After the exit wait, BURST_LEN AutoRefresh commands follow: the first in cycle exit+T_RC+1, the rest T_WAIT+1 cycles apart. The sequence then ends with the done pulse.
- R11: Between sequences (ref_req and ref_done low, not in self-refresh) the block drives Deselect with cke=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Level request for self-refresh: high to enter and stay, low to leave |
| ref_gnt | input | 1 | Arbiter grant: both banks are idle and the command bus is yielded |
| ref_req | output | 1 | Request to the arbiter for the command bus |
| ref_done | output | 1 | One-cycle pulse when a refresh or self-refresh sequence ends |
| sr_active | output | 1 | High while the memory is held in self-refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |

## Verification
The assertions assume the arbiter raises ref_gnt only while ref_req is high and keeps it high until ref_req falls. They also assume sr_req changes only between clock edges. The stimulus keeps to these rules: the grant is driven from ref_req after a random delay, or held off for several refresh intervals to test merging of expired intervals. The self-refresh request is raised at random times, including during a periodic sequence, and dropped after a random stay or during the pre-entry burst. Expected request, command and done cycles are computed from the interval grid and the wait lengths.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
    } sdram_cmd_t;

    localparam sdram_cmd_t CMD_DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
    localparam sdram_cmd_t CMD_NOP      = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
    localparam sdram_cmd_t CMD_AUTOREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b1};
    localparam sdram_cmd_t CMD_SR_ENTRY = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b0};
    localparam sdram_cmd_t CMD_SR_KEEP  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b0};

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ,
        S_REF_CMD,
        S_WAIT,
        S_SR_ENTER,
        S_SR_HOLD,
        S_SR_EXIT,
        S_SR_WAIT,
        S_DONE
    } sref_state_t;

endpackage

// File: rtl/sref_interval_timer.sv
module sref_interval_timer #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic pending
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= RELOAD;
            pending <= 1'b0;
        end else begin
            if (cnt == '0) begin
                cnt <= RELOAD;
            end else begin
                cnt <= cnt - 1'b1;
            end
            if (cnt == '0) begin
                pending <= 1'b1;
            end else if (clear) begin
                pending <= 1'b0;
            end
        end
    end

    // R2: expiry reloads the counter and marks a refresh pending
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> (pending && cnt == RELOAD));

    // R3: a pending refresh is held until a refresh command clears it
    p_pending_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> pending);

endmodule

// File: rtl/sref_wait_timer.sv
module sref_wait_timer #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] len,
    output logic [WW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == WW'(1));

    // R5: the countdown only moves down by one or is reloaded
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sref_seq_fsm.sv
module sref_seq_fsm
    import sdram_ref_pkg::*;
#(
    parameter int T_RC      = 5,
    parameter int T_RP      = 7,
    parameter int BURST_LEN = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pending,
    input  logic        ref_gnt,
    input  logic        sr_req,
    input  logic        wait_last,
    output logic        wait_load,
    output logic [$clog2(((T_RC > T_RP) ? T_RC : T_RP) + 1)-1:0] wait_len,
    output logic        clear,
    output sdram_cmd_t  cmd,
    output logic        ref_req,
    output logic        ref_done,
    output logic        sr_active
);
    localparam int T_WAIT = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int WW     = $clog2(T_WAIT + 1);
    localparam int BW     = $clog2(BURST_LEN + 1);

    sref_state_t   state, nxt;
    logic          seq_sr, seq_sr_n;
    logic          post, post_n;
    logic [BW-1:0] burst_left, burst_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            seq_sr     <= 1'b0;
            post       <= 1'b0;
            burst_left <= '0;
        end else begin
            state      <= nxt;
            seq_sr     <= seq_sr_n;
            post       <= post_n;
            burst_left <= burst_n;
        end
    end

    always_comb begin
        nxt       = state;
        seq_sr_n  = seq_sr;
        post_n    = post;
        burst_n   = burst_left;
        wait_load = 1'b0;
        wait_len  = '0;
        unique case (state)
            S_IDLE: begin
                if (sr_req) begin
                    nxt      = S_REQ;
                    seq_sr_n = 1'b1;
                    post_n   = 1'b0;
                    burst_n  = BW'(BURST_LEN);
                end else if (pending) begin
                    nxt      = S_REQ;
                    seq_sr_n = 1'b0;
                    post_n   = 1'b0;
                end
            end
            S_REQ: begin
                if (ref_gnt) begin
                    if (seq_sr && burst_left == '0) begin
                        nxt = S_SR_ENTER;
                    end else begin
                        nxt = S_REF_CMD;
                    end
                end
            end
            S_REF_CMD: begin
                wait_load = 1'b1;
                wait_len  = WW'(T_WAIT);
                if (seq_sr) begin
                    burst_n = burst_left - 1'b1;
                end
                nxt = S_WAIT;
            end
            S_WAIT: begin
                if (wait_last) begin
                    if (seq_sr && burst_left != '0) begin
                        nxt = S_REF_CMD;
                    end else if (seq_sr && !post) begin
                        nxt = S_SR_ENTER;
                    end else begin
                        nxt = S_DONE;
                    end
                end
            end
            S_SR_ENTER: begin
                nxt = S_SR_HOLD;
            end
            S_SR_HOLD: begin
                if (!sr_req) begin
                    nxt = S_SR_EXIT;
                end
            end
            S_SR_EXIT: begin
                wait_load = 1'b1;
                wait_len  = WW'(T_RC);
                post_n    = 1'b1;
                burst_n   = BW'(BURST_LEN);
                nxt       = S_SR_WAIT;
            end
            S_SR_WAIT: begin
                if (wait_last) begin
                    nxt = (burst_left != '0) ? S_REF_CMD : S_DONE;
                end
            end
            S_DONE: begin
                seq_sr_n = 1'b0;
                post_n   = 1'b0;
                nxt      = S_IDLE;
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    always_comb begin
        cmd       = CMD_DESELECT;
        ref_req   = 1'b0;
        ref_done  = 1'b0;
        sr_active = 1'b0;
        clear     = 1'b0;
        unique case (state)
            S_IDLE: begin
                cmd = CMD_DESELECT;
            end
            S_REQ: begin
                ref_req = 1'b1;
            end
            S_REF_CMD: begin
                cmd     = CMD_AUTOREF;
                ref_req = 1'b1;
                clear   = 1'b1;
            end
            S_WAIT: begin
                cmd     = CMD_NOP;
                ref_req = 1'b1;
            end
            S_SR_ENTER: begin
                cmd     = CMD_SR_ENTRY;
                ref_req = 1'b1;
            end
            S_SR_HOLD: begin
                cmd       = CMD_SR_KEEP;
                ref_req   = 1'b1;
                sr_active = 1'b1;
            end
            S_SR_EXIT: begin
                cmd     = CMD_NOP;
                ref_req = 1'b1;
            end
            S_SR_WAIT: begin
                cmd     = CMD_NOP;
                ref_req = 1'b1;
            end
            S_DONE: begin
                ref_done = 1'b1;
            end
            default: begin
                cmd = CMD_DESELECT;
            end
        endcase
    end

    // R3: the request is not withdrawn before the grant arrives
    p_req_until_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt && state == S_REQ) |=> ref_req);

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);

    // R7: burst bookkeeping never exceeds the configured length
    p_burst_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_sr |-> (burst_left <= BW'(BURST_LEN)));

    // R8: clock-enable stays low while self-refresh is still requested
    p_cke_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SR_HOLD && sr_req) |=> (!cmd.cke && sr_active));

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
    import sdram_ref_pkg::*;
#(
    parameter int REF_INTERVAL = 1953,
    parameter int T_RC         = 5,
    parameter int T_RP         = 7,
    parameter int BURST_LEN    = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_done,
    output logic sr_active,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke
);
    localparam int T_WAIT = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int WW     = $clog2(T_WAIT + 1);

    logic          pending;
    logic          clear;
    logic          wait_load;
    logic [WW-1:0] wait_len;
    logic [WW-1:0] wait_cnt;
    logic          wait_last;
    sdram_cmd_t    cmd;

    sref_interval_timer #(
        .INTERVAL(REF_INTERVAL)
    ) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .pending (pending)
    );

    sref_wait_timer #(
        .WW(WW)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wait_load),
        .len   (wait_len),
        .cnt   (wait_cnt),
        .last  (wait_last)
    );

    sref_seq_fsm #(
        .T_RC      (T_RC),
        .T_RP      (T_RP),
        .BURST_LEN (BURST_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .ref_gnt   (ref_gnt),
        .sr_req    (sr_req),
        .wait_last (wait_last),
        .wait_load (wait_load),
        .wait_len  (wait_len),
        .clear     (clear),
        .cmd       (cmd),
        .ref_req   (ref_req),
        .ref_done  (ref_done),
        .sr_active (sr_active)
    );

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign cke   = cmd.cke;

    // R4: a refresh-encoded command is only driven after a cycle with cke high
    p_refresh_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && we_n) |-> $past(cke));

    // R5: each AutoRefresh arms the recovery window with its full length
    p_wait_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && we_n && cke) |=> (wait_cnt == WW'(T_WAIT)));

    // R9: clock-enable rises only together with a NOP or Deselect
    p_exit_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cs_n || (ras_n && cas_n && we_n)));

endmodule

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;

    localparam int IVL   = 64;
    localparam int TRC   = 5;
    localparam int TRP   = 7;
    localparam int BURST = 3;
    localparam int TW    = (TRC > TRP) ? TRC : TRP;

    logic clk = 1'b0;
    logic rst_n;
    logic sr_req;
    logic ref_gnt;
    logic ref_req, ref_done, sr_active;
    logic cs_n, ras_n, cas_n, we_n, cke;

    always #4 clk = ~clk;

    sdram_refresh_sched #(
        .REF_INTERVAL (IVL),
        .T_RC         (TRC),
        .T_RP         (TRP),
        .BURST_LEN    (BURST)
    ) u_sdram_refresh_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .sr_req    (sr_req),
        .ref_gnt   (ref_gnt),
        .ref_req   (ref_req),
        .ref_done  (ref_done),
        .sr_active (sr_active),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cke       (cke)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit reported = 1'b0;

    bit chk_period = 1'b0;
    bit stall      = 1'b0;
    int gnt_max    = 15;
    int gdly       = 0;

    int n_done    = 0;
    int n_sr_done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    function automatic int next_req_cycle(input int cmd_cyc);
        int m;
        int ready;
        m     = ((cmd_cyc + IVL) / IVL) * IVL;
        ready = cmd_cyc + TW + 3;
        return (m + 1 > ready) ? m + 1 : ready;
    endfunction

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
    end

    // grant model: grant after a random delay, held until the request drops
    initial begin
        ref_gnt = 1'b0;
        forever begin
            @(negedge clk);
            if (!ref_req) begin
                ref_gnt = 1'b0;
                gdly    = $urandom_range(0, gnt_max);
            end else if (!stall) begin
                if (gdly == 0) ref_gnt = 1'b1;
                else gdly--;
            end
        end
    end

    // protocol monitor
    initial begin
        bit prev_cke, prev_req, prev_done, gnt_seen, in_sr, post, have_aref;
        int pred, cnt_ref, last_cmd, last_aref, enter_cyc, exit_cyc, exp_exit;
        bit is_aref, is_enter, is_nop, is_desel;
        prev_cke = 1'b1; prev_req = 1'b0; prev_done = 1'b0; gnt_seen = 1'b0;
        in_sr = 1'b0; post = 1'b0; have_aref = 1'b0;
        pred = IVL + 1; cnt_ref = 0; last_cmd = -100; last_aref = -100;
        enter_cyc = 0; exit_cyc = -100; exp_exit = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && cyc > 0) begin
                is_aref  = !cs_n && !ras_n && !cas_n && we_n && cke;
                is_enter = !cs_n && !ras_n && !cas_n && we_n && !cke;
                is_nop   = !cs_n && ras_n && cas_n && we_n;
                is_desel = cs_n;

                if (ref_req && !prev_req) begin
                    cnt_ref  = 0;
                    gnt_seen = 1'b0;
                    if (chk_period) check(cyc == pred, "R2 request cycle", cyc, pred);
                end
                if (stall && prev_req && !gnt_seen) check(ref_req, "R3 request held", ref_req, 1);

                if (have_aref && cyc > last_aref && cyc <= last_aref + TW)
                    check(is_nop && cke, "R5 nop window", {cs_n, ras_n, cas_n, we_n, cke}, 5'b01111);

                if (is_aref) begin
                    check(prev_cke, "R4 cke before refresh", prev_cke, 1);
                    check(ref_req && gnt_seen, "R4 refresh after grant", gnt_seen, 1);
                    if (post && cnt_ref == 0)
                        check(cyc == exit_cyc + TRC + 1, "R10 first post-exit refresh", cyc, exit_cyc + TRC + 1);
                    else if (cnt_ref > 0)
                        check(cyc == last_cmd + TW + 1, "R7 burst spacing", cyc - last_cmd, TW + 1);
                    if (chk_period) pred = next_req_cycle(cyc);
                    last_cmd  = cyc;
                    last_aref = cyc;
                    have_aref = 1'b1;
                    cnt_ref++;
                end

                if (is_enter) begin
                    check(prev_cke, "R4 cke before entry", prev_cke, 1);
                    check(cnt_ref == BURST, "R7 pre-entry burst count", cnt_ref, BURST);
                    check(cyc == last_cmd + TW + 1, "R7 entry spacing", cyc - last_cmd, TW + 1);
                    in_sr     = 1'b1;
                    enter_cyc = cyc;
                    exp_exit  = 0;
                    cnt_ref   = 0;
                end else if (in_sr) begin
                    if (!cke) begin
                        check(is_desel && sr_active, "R8 hold deselect", {cs_n, sr_active}, 2'b11);
                    end else begin
                        check(is_nop || is_desel, "R9 exit command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
                        check(cyc == exp_exit, "R9 exit cycle", cyc, exp_exit);
                        in_sr    = 1'b0;
                        post     = 1'b1;
                        exit_cyc = cyc;
                        cnt_ref  = 0;
                    end
                end
                if (in_sr && !sr_req && exp_exit == 0)
                    exp_exit = ((cyc > enter_cyc + 1) ? cyc : enter_cyc + 1) + 1;

                if (post && cyc > exit_cyc && cyc <= exit_cyc + TRC)
                    check(is_nop && cke, "R9 post-exit nop", {cs_n, ras_n, cas_n, we_n, cke}, 5'b01111);

                if (ref_done) begin
                    int exp_d;
                    exp_d = (cnt_ref > 0) ? last_cmd + TW + 1 : exit_cyc + TRC + 1;
                    check(cyc == exp_d, "R6 done cycle", cyc, exp_d);
                    check(!ref_req, "R6 request low at done", ref_req, 0);
                    check(!prev_done, "R6 single pulse", prev_done, 0);
                    if (post) begin
                        check(cnt_ref == BURST, "R10 post-exit burst count", cnt_ref, BURST);
                        n_sr_done++;
                    end else begin
                        check(cnt_ref == 1, "R3 one refresh per grant", cnt_ref, 1);
                    end
                    post = 1'b0;
                    n_done++;
                end

                if (!ref_req && !ref_done && !in_sr)
                    check(is_desel && cke, "R11 idle deselect", {cs_n, cke}, 2'b11);

                if (ref_gnt && ref_req) gnt_seen = 1'b1;
                prev_cke  = cke;
                prev_req  = ref_req;
                prev_done = ref_done;
            end
        end
    end

    task automatic wait_count(ref int counter, input int target, input string what);
        int guard;
        guard = 0;
        while (counter < target && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (counter < target) check(1'b0, what, counter, target);
    endtask

    task automatic wait_level(input bit want_active, input string what);
        int guard;
        guard = 0;
        while ((want_active ? !sr_active : ref_req) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 5000) check(1'b0, what, guard, 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R2 watchdog expired", cyc, 0);
        report();
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n  = 1'b0;
        sr_req = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(cs_n && ras_n && cas_n && we_n, "R1 reset command", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
        check(cke, "R1 reset cke", cke, 1);
        check(!ref_req && !ref_done && !sr_active, "R1 reset flags", {ref_req, ref_done, sr_active}, 0);

        // periodic refreshes with random grant delays
        chk_period = 1'b1;
        gnt_max    = 15;
        wait_count(n_done, 25, "R2 periodic sequences");

        // grant withheld across several intervals: expiries merge (R3)
        while (ref_req) @(negedge clk);
        stall = 1'b1;
        while (!ref_req) @(negedge clk);
        repeat (3 * IVL) @(negedge clk);
        stall = 1'b0;
        wait_count(n_done, n_done + 4, "R3 after stall");

        // self-refresh episodes
        chk_period = 1'b0;
        for (int ep = 0; ep < 7; ep++) begin
            int target;
            target = n_sr_done + 1;
            repeat ($urandom_range(1, 80)) @(negedge clk);
            sr_req = 1'b1;
            wait_level(1'b1, "R7 entry reached");
            repeat ($urandom_range(0, 30)) @(negedge clk);
            sr_req = 1'b0;
            wait_count(n_sr_done, target, "R10 self-refresh sequence");
        end

        // directed: request dropped during the pre-entry burst (R9)
        begin
            int target;
            target = n_sr_done + 1;
            wait_level(1'b0, "R11 idle before drop test");
            sr_req = 1'b1;
            while (!ref_req) @(negedge clk);
            repeat (2) @(negedge clk);
            sr_req = 1'b0;
            wait_count(n_sr_done, target, "R9 early drop sequence");
        end

        repeat (3 * IVL) @(negedge clk);
        report();
        $finish;
    end

endmodule